// File: doc/BRIEF.md
# Command Mailbox Requester

This block is a bus master that carries out one complete command exchange with a memory-subsystem mailbox. The mailbox is reached through a simple 32-bit register port. A one-cycle start pulse hands the engine a target descriptor (IP type, instance number, command class, opcode), seven parameter words and the number of response words wanted. The engine then walks the mailbox handshake on its own.

First it waits until the request slot is empty. It then writes the non-zero parameters and posts the packed command word. It polls for the response-ready flag and collects the status and data words. Finally it hands the ready flag back to the mailbox.

Results are held on the outputs until the next accepted start. They are the captured status word, its short-data and error-code fields, up to three data words, and error, timeout and invalid-count flags. A single-cycle done pulse closes every exchange, whether it succeeded or failed.

The register port has no bursts. A read issued in one cycle has its data on `bus_rdata` in the next cycle, and a write completes in the cycle it is issued. Each polling phase may make at most `POLL_LIMIT` reads.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After an accepted start, the engine reads offset 0x43C and repeats until it returns all-zero, before it makes any write. If `POLL_LIMIT` reads all return non-zero, it ends with `err` and `timeout` high and performs no write.
- R2: Parameter k (k = 0..6, `params[32k+31:32k]`) is written to offset 0x438 − 4k, in rising k order, before the command word. A parameter equal to zero is not written.
- R3: The command word is written once to 0x43C, with IP type in bits [31:29], instance in [28:24], command class in [23:16] and opcode in [15:0].
- R4: The engine then reads 0x45C until bit 0 is set. If `POLL_LIMIT` reads all show bit 0 clear, it ends with `err` and `timeout` high. In that case `status` holds the last value read, no data read and no clear write follow, `gen_code` = status[4:1] and `rsp_code` = status[7:5].
- R5: Each polling phase makes at most `POLL_LIMIT` reads, and the count restarts for each phase. A condition first met on the last permitted read counts as success, not timeout.
- R6: On success, `status` captures the ready word. For a requested count n ≤ 3, data word i (i < n) is read from 0x458 − 4i in rising i order into `rsp_data[32i+31:32i]`. Unread words are zero.
- R7: A requested count above 3 performs no data read, leaves all data words zero and raises `cnt_invalid`. `err` stays low and the clear step still runs.
- R8: A successful exchange ends by reading 0x45C and writing back the value read with only bit 0 cleared.
- R9: `short_data` always equals status[31:16].
- R10: `done` is high for exactly one cycle at the end of every exchange. `busy` is high from the cycle after an accepted start until `done` has been given.
- R11: A start pulse while `busy` is high is ignored. The running exchange is unaffected and no second exchange follows.
- R12: After reset the engine is idle, all result outputs are zero and the register port issues neither reads nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| ip_type | input | 3 | Target IP type |
| inst_id | input | 5 | Target instance number |
| cmd_class | input | 8 | Command class |
| opcode | input | 16 | Command opcode |
| params | input | 224 | Seven parameter words, word k at [32k+31:32k] |
| rsp_count | input | 3 | Response data words wanted (0..3 valid) |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| err | output | 1 | Exchange failed |
| timeout | output | 1 | Failure was a poll timeout |
| cnt_invalid | output | 1 | Requested count exceeded 3 |
| status | output | 32 | Captured response status word |
| short_data | output | 16 | Status bits [31:16] |
| gen_code | output | 4 | Status bits [4:1] |
| rsp_code | output | 3 | Status bits [7:5] |
| rsp_data | output | 96 | Response data words, word i at [32i+31:32i] |
| bus_rd | output | 1 | Register read request |
| bus_wr | output | 1 | Register write request |
| bus_addr | output | 12 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The key coincidence is the one in R5: the limit check and the success check both fall on the same returning poll read. The bench provokes it by having the responder clear the request slot only on the last permitted pre-poll read, and raise the ready bit only on the last permitted status read. The engine must treat both as success. This is judged from the error flags, the captured status, the exact number of reads in each phase and the presence of the clear write. A second coincidence is a start pulse that arrives while an exchange is still running. It is judged by the single command write, the unchanged opcode and the single done pulse.

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine #(
  parameter int POLL_LIMIT = 8,
  parameter int AW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     ip_type,
  input  logic [4:0]     inst_id,
  input  logic [7:0]     cmd_class,
  input  logic [15:0]    opcode,
  input  logic [223:0]   params,
  input  logic [2:0]     rsp_count,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           timeout,
  output logic           cnt_invalid,
  output logic [31:0]    status,
  output logic [15:0]    short_data,
  output logic [3:0]     gen_code,
  output logic [2:0]     rsp_code,
  output logic [95:0]    rsp_data,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [AW-1:0]  bus_addr,
  output logic [31:0]    bus_wdata,
  input  logic [31:0]    bus_rdata
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [AW-1:0] REQ_OFS  = AW'(12'h43C);
  localparam logic [AW-1:0] PRM0_OFS = AW'(12'h438);
  localparam logic [AW-1:0] RSP_OFS  = AW'(12'h45C);
  localparam logic [AW-1:0] DAT0_OFS = AW'(12'h458);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_PARAM, S_CMD, S_RSP, S_DATA, S_CLRR, S_CLRW, S_DONE
  } st_t;

  st_t           st;
  logic          rd_pend;
  logic [2:0]    idx;
  logic [PW-1:0] polls;
  logic [31:0]   cmd_word;
  logic [31:0]   prm [0:7];
  logic [2:0]    cnt;
  logic [31:0]   dw [0:2];
  logic [31:0]   clr_val;
  logic          limit_hit;

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign short_data = status[31:16];
  assign gen_code   = status[4:1];
  assign rsp_code   = status[7:5];
  assign rsp_data   = {dw[2], dw[1], dw[0]};
  assign limit_hit  = (polls >= PW'(POLL_LIMIT));

  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_REQ:   if (!rd_pend) begin bus_rd = 1'b1; bus_addr = REQ_OFS; end
      S_PARAM: if (prm[idx] != 32'd0) begin
                 bus_wr    = 1'b1;
                 bus_addr  = PRM0_OFS - AW'({idx, 2'b00});
                 bus_wdata = prm[idx];
               end
      S_CMD:   begin bus_wr = 1'b1; bus_addr = REQ_OFS; bus_wdata = cmd_word; end
      S_RSP:   if (!rd_pend) begin bus_rd = 1'b1; bus_addr = RSP_OFS; end
      S_DATA:  if (!rd_pend && cnt <= 3'd3 && idx < cnt) begin
                 bus_rd   = 1'b1;
                 bus_addr = DAT0_OFS - AW'({idx, 2'b00});
               end
      S_CLRR:  if (!rd_pend) begin bus_rd = 1'b1; bus_addr = RSP_OFS; end
      S_CLRW:  begin bus_wr = 1'b1; bus_addr = RSP_OFS; bus_wdata = clr_val; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rd_pend     <= 1'b0;
      idx         <= '0;
      polls       <= '0;
      cmd_word    <= '0;
      cnt         <= '0;
      clr_val     <= '0;
      status      <= '0;
      err         <= 1'b0;
      timeout     <= 1'b0;
      cnt_invalid <= 1'b0;
      for (int k = 0; k < 8; k++) prm[k] <= '0;
      for (int k = 0; k < 3; k++) dw[k] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cmd_word    <= {ip_type, inst_id, cmd_class, opcode};
          for (int k = 0; k < 7; k++) prm[k] <= params[32*k +: 32];
          prm[7]      <= '0;
          cnt         <= rsp_count;
          status      <= '0;
          err         <= 1'b0;
          timeout     <= 1'b0;
          cnt_invalid <= 1'b0;
          for (int k = 0; k < 3; k++) dw[k] <= '0;
          polls       <= '0;
          rd_pend     <= 1'b0;
          st          <= S_REQ;
        end
        S_REQ: begin
          if (!rd_pend) begin
            rd_pend <= 1'b1;
            polls   <= polls + 1'b1;
          end else begin
            rd_pend <= 1'b0;
            if (bus_rdata == 32'd0) begin
              idx <= '0;
              st  <= S_PARAM;
            end else if (limit_hit) begin
              err     <= 1'b1;
              timeout <= 1'b1;
              st      <= S_DONE;
            end
          end
        end
        S_PARAM: begin
          idx <= idx + 1'b1;
          if (idx == 3'd6) st <= S_CMD;
        end
        S_CMD: begin
          polls <= '0;
          st    <= S_RSP;
        end
        S_RSP: begin
          if (!rd_pend) begin
            rd_pend <= 1'b1;
            polls   <= polls + 1'b1;
          end else begin
            rd_pend <= 1'b0;
            if (bus_rdata[0]) begin
              status <= bus_rdata;
              idx    <= '0;
              st     <= S_DATA;
            end else if (limit_hit) begin
              status  <= bus_rdata;
              err     <= 1'b1;
              timeout <= 1'b1;
              st      <= S_DONE;
            end
          end
        end
        S_DATA: begin
          if (cnt > 3'd3) begin
            cnt_invalid <= 1'b1;
            st          <= S_CLRR;
          end else if (idx >= cnt) begin
            st <= S_CLRR;
          end else if (!rd_pend) begin
            rd_pend <= 1'b1;
          end else begin
            rd_pend      <= 1'b0;
            dw[idx[1:0]] <= bus_rdata;
            idx          <= idx + 1'b1;
          end
        end
        S_CLRR: begin
          if (!rd_pend) begin
            rd_pend <= 1'b1;
          end else begin
            rd_pend <= 1'b0;
            clr_val <= bus_rdata & ~32'd1;
            st      <= S_CLRW;
          end
        end
        S_CLRW: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RSP_OFS) |-> !bus_wdata[0]);

  // R7
  inv_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_invalid |-> (rsp_data == 96'd0 && !err));

  // R12
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr));

  // R4
  tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> err);
endmodule

// File: tb/mbox_cmd_engine_test.sv
module mbox_cmd_engine_test;
  localparam int L = 8;
  localparam int NV = 6;

  localparam logic [6:0]  T_MASK [NV] = '{7'h7F, 7'h55, 7'h00, 7'h41, 7'h08, 7'h7F};
  localparam int          T_CNT  [NV] = '{3, 1, 0, 2, 5, 2};
  localparam int          T_BUSY [NV] = '{0, 3, 7, 0, 0, 8};
  localparam int          T_THR  [NV] = '{1, 4, 8, 0, 2, 1};
  localparam logic [31:0] T_STAT [NV] = '{32'hBEEF_0000, 32'h1234_00E0, 32'h0001_001E,
                                          32'hCAFE_00B6, 32'h00FF_0F00, 32'h5555_0000};

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] ip_type = 0; logic [4:0] inst_id = 0;
  logic [7:0] cmd_class = 0; logic [15:0] opcode = 0;
  logic [223:0] params = '0; logic [2:0] rsp_count = 0;
  logic busy, done, err, timeout, cnt_invalid;
  logic [31:0] status; logic [15:0] short_data; logic [3:0] gen_code; logic [2:0] rsp_code;
  logic [95:0] rsp_data;
  logic bus_rd, bus_wr; logic [11:0] bus_addr; logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = 0;

  always #2.5 clk = ~clk;

  mbox_cmd_engine #(.POLL_LIMIT(L)) uut (.*);

  int errors = 0, checks = 0;
  int busy_n = 0, thr = 0;
  logic [31:0] stat_val = 0;
  logic [31:0] dat [3];
  logic [31:0] exp_p [7];
  int req_reads, rsp_reads, data_reads, cmd_wr_cnt, clr_cnt, done_cnt, last_k;
  logic [6:0] pw_mask; logic param_bad, order_bad, addr_bad, write_early;
  logic [31:0] cmd_val, clr_val;

  task automatic clear_log();
    req_reads = 0; rsp_reads = 0; data_reads = 0; cmd_wr_cnt = 0; clr_cnt = 0;
    done_cnt = 0; last_k = -1; pw_mask = 0; param_bad = 0; order_bad = 0;
    addr_bad = 0; write_early = 0; cmd_val = 0; clr_val = 0;
  endtask

  always @(posedge clk) begin
    if (done) done_cnt++;
    if (bus_rd) begin
      if (bus_addr == 12'h43C) begin
        bus_rdata <= (req_reads < busy_n) ? 32'h1 : 32'h0;
        req_reads++;
      end else if (bus_addr == 12'h45C) begin
        bus_rdata <= (thr != 0 && rsp_reads + 1 >= thr) ? (stat_val | 32'd1) : (stat_val & ~32'd1);
        rsp_reads++;
      end else begin
        if (data_reads > 2 || bus_addr != 12'h458 - 12'(4 * data_reads)) addr_bad = 1;
        else bus_rdata <= dat[data_reads];
        data_reads++;
      end
    end
    if (bus_wr) begin
      if (req_reads == 0) write_early = 1;
      if (bus_addr >= 12'h420 && bus_addr <= 12'h438) begin
        int k;
        k = (12'h438 - bus_addr) / 4;
        if (k <= last_k || cmd_wr_cnt != 0) order_bad = 1;
        last_k = k;
        pw_mask[k] = 1;
        if (bus_wdata != exp_p[k]) param_bad = 1;
      end else if (bus_addr == 12'h43C) begin
        cmd_wr_cnt++; cmd_val = bus_wdata;
      end else if (bus_addr == 12'h45C) begin
        clr_cnt++; clr_val = bus_wdata;
      end else addr_bad = 1;
    end
  end

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (done_cnt > 0) begin ok = 1; break; end
    end
    if (!ok) chk("R10 watchdog", 0, 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) dat[i] = 32'hD000_0000 + 32'(i);
    clear_log();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 0); chk("R12 done", done, 0); chk("R12 err", {err, timeout, cnt_invalid}, 0);
    chk("R12 status", status, 0); chk("R12 data", rsp_data, 0); chk("R12 bus", {bus_rd, bus_wr}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R12 bus idle", {bus_rd, bus_wr, busy}, 0);

    for (int v = 0; v < NV; v++) begin
      bit ok, pre_tmo, rsp_tmo, succ;
      int nrd;
      logic [31:0] exp_stat, exp_cmd;
      logic [95:0] exp_data;
      clear_log();
      busy_n = T_BUSY[v]; thr = T_THR[v]; stat_val = T_STAT[v];
      for (int k = 0; k < 7; k++) begin
        exp_p[k] = T_MASK[v][k] ? (32'hA000_0000 | 32'(v << 8) | 32'(k)) : 32'd0;
        params[32*k +: 32] = exp_p[k];
      end
      ip_type = 3'(v + 1); inst_id = 5'(3 * v + 2); cmd_class = 8'(16 * v + 5);
      opcode = 16'(16'h1000 + v); rsp_count = 3'(T_CNT[v]);
      exp_cmd = {ip_type, inst_id, cmd_class, opcode};
      pre_tmo = (busy_n >= L);
      rsp_tmo = !pre_tmo && (thr == 0 || thr > L);
      succ = !pre_tmo && !rsp_tmo;
      exp_stat = pre_tmo ? 32'd0 : rsp_tmo ? (stat_val & ~32'd1) : (stat_val | 32'd1);
      nrd = (succ && T_CNT[v] <= 3) ? T_CNT[v] : 0;
      exp_data = '0;
      for (int i = 0; i < 3; i++) if (i < nrd) exp_data[32*i +: 32] = dat[i];
      pulse_start();
      wait_done(ok);
      chk($sformatf("R1 v%0d pre-poll reads", v), req_reads, pre_tmo ? L : busy_n + 1);
      chk($sformatf("R1 v%0d no early write", v), write_early, 0);
      chk($sformatf("R2 v%0d param mask", v), pw_mask, pre_tmo ? 7'h0 : T_MASK[v]);
      chk($sformatf("R2 v%0d param value/order", v), {param_bad, order_bad, addr_bad}, 0);
      chk($sformatf("R3 v%0d cmd writes", v), cmd_wr_cnt, pre_tmo ? 0 : 1);
      if (!pre_tmo) chk($sformatf("R3 v%0d cmd word", v), cmd_val, exp_cmd);
      chk($sformatf("R4 v%0d err/timeout", v), {err, timeout}, succ ? 2'b00 : 2'b11);
      chk($sformatf("R5 v%0d status reads", v), rsp_reads, pre_tmo ? 0 : rsp_tmo ? L : thr + 1);
      chk($sformatf("R4 v%0d status", v), status, exp_stat);
      chk($sformatf("R4 v%0d gen code", v), gen_code, exp_stat[4:1]);
      chk($sformatf("R4 v%0d rsp code", v), rsp_code, exp_stat[7:5]);
      chk($sformatf("R9 v%0d short data", v), short_data, exp_stat[31:16]);
      chk($sformatf("R6 v%0d data reads", v), data_reads, nrd);
      chk($sformatf("R6 v%0d data words", v), rsp_data, exp_data);
      chk($sformatf("R7 v%0d invalid", v), cnt_invalid, succ && T_CNT[v] > 3);
      chk($sformatf("R8 v%0d clear writes", v), clr_cnt, succ ? 1 : 0);
      if (succ) chk($sformatf("R8 v%0d clear value", v), clr_val, stat_val & ~32'd1);
      chk($sformatf("R10 v%0d done cycles", v), done_cnt, 1);
      chk($sformatf("R10 v%0d busy after", v), busy, 0);
    end

    // R11: start while busy is ignored
    begin
      bit ok;
      clear_log();
      busy_n = 0; thr = 6; stat_val = 32'h0BAD_0000;
      for (int k = 0; k < 7; k++) exp_p[k] = 0;
      params = '0; ip_type = 3'd2; inst_id = 5'd9; cmd_class = 8'h33; opcode = 16'h00AA; rsp_count = 3'd1;
      pulse_start();
      repeat (4) @(negedge clk);
      chk("R10 busy during run", busy, 1);
      opcode = 16'h00BB;
      start = 1; @(negedge clk); start = 0;
      repeat (8) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
      wait_done(ok);
      repeat (40) @(negedge clk);
      chk("R11 one command", cmd_wr_cnt, 1);
      chk("R11 first opcode kept", cmd_val, {3'd2, 5'd9, 8'h33, 16'h00AA});
      chk("R11 one done", done_cnt, 1);
      chk("R11 idle after", busy, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule